// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel Register Block

This block is the register front end and counter engine of a bus-master DMA channel that sits beside a SCSI protocol core on a 32-bit I/O bus. Through the bus, software loads a starting count, a starting memory address and a starting descriptor-list address. It then issues commands through a two-bit opcode field. A START opcode copies the starting values into working copies, clears the status byte and enables the channel. The I/O window also passes accesses in its lower region through to the SCSI core. Narrow writes are widened into full words by merging them with the register's current contents.

The SCSI core moves data through a transfer side-port. Each request carries a length and a direction. A request is accepted only while the channel is enabled and its direction agrees with the direction bit of the command register. The block clamps the length to the remaining working count and returns the granted length and the memory address in the same cycle. It then decrements the count and advances the address. Status bits are cleared in one of two ways, selected by a bit of a separate bus-control register: on read, or by writing ones. Descriptor-list transfers and the flush opcode are decoded but have no effect.

Top module: `scsi_dma_regs`

## Requirements
- R1: After reset, the command register (0x40) and working count (0x50) read 0, the status register (0x58) reads 0, the working address (0x54) reads 0xFFFFFFFF and the working descriptor address (0x5C) reads 0xFFFFFFFD. chan_en, irq and xfer_ready are low.
- R2: Writing the command register with opcode 3 (bits 1:0) copies start count 0x44 into 0x50, start address 0x48 into 0x54 and start descriptor 0x4C into 0x5C. It clears status bits 5:0 and raises chan_en.
- R3: Opcode 0 lowers chan_en. Opcode 2 raises abort_req for exactly one cycle. Opcode 1 changes neither chan_en nor the working registers.
- R4: An accepted transfer grants min(xfer_len, working count) and presents the working address on xfer_addr in the same cycle. At the next edge the count drops by the grant and the address rises by it.
- R5: A request whose xfer_dir differs from command bit 7 (1 = device to memory), or one made while the channel is disabled, grants 0 and leaves the count unchanged. xfer_ready follows chan_en.
- R6: The done bit (status bit 3) is set when a transfer brings the working count to zero. A core_cmd_done pulse forces the working count to 0 and sets done.
- R7: A status read returns bit 4 set whenever core_irq is high, whatever the stored value.
- R8: While bus-control bit 24 is 0, a status read returns the value and then clears status bits 1, 2 and 3.
- R9: While bus-control bit 24 is 1, status reads do not clear anything. A status write clears each of bits 1, 2 and 3 that is 1 in the written data.
- R10: A byte (io_size 0) or half-word (io_size 1) write at byte offset io_addr[1:0] replaces only those byte lanes of the addressed register. The data is taken from the low bits of io_wdata.
- R11: Reads return the addressed word shifted right by 8 × io_addr[1:0] and masked to the access size. Addresses 0x60–0x6F and 0x74 upward read 0.
- R12: irq is high when done is set with command bit 6, or when core_irq is high with command bit 5.
- R13: Accesses below 0x40 go to the core: core_addr = io_addr[5:2], with the widened write word on core_wdata, merged against core_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | IO_AW | Byte address of the I/O access |
| io_size | input | 2 | Access size: 0 byte, 1 half-word, 2 or 3 word |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 32 | Right-aligned write data |
| io_rdata | output | 32 | Read data, valid in the cycle of io_rd |
| core_addr | output | 4 | Word index of the core register |
| core_wr | output | 1 | Core register write strobe |
| core_rd | output | 1 | Core register read strobe |
| core_wdata | output | 32 | Widened write word for the core |
| core_rdata | input | 32 | Current word of the addressed core register |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| core_cmd_done | input | 1 | Pulse when the SCSI command completes |
| chan_en | output | 1 | Channel enabled |
| abort_req | output | 1 | One-cycle request to cancel the active command |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_dir | input | 1 | Request direction, 1 = device to memory |
| xfer_len | input | LEN_W | Requested length in bytes |
| xfer_ready | output | 1 | Channel can accept a request |
| xfer_grant | output | LEN_W | Granted length, 0 when rejected |
| xfer_addr | output | 32 | Memory address for this burst |
| irq | output | 1 | Channel interrupt |

## Verification
Read data, the transfer grant, the transfer address, the core pass-through strobes and irq are combinational. The bench drives stimulus on the falling edge and samples these outputs 1 ns later, before the next rising edge. Register updates (START loads, count and address changes, status clears, chan_en) take effect at the first rising edge after the stimulus, so the bench confirms them with a read in a later cycle. abort_req is registered: it is checked just after that edge and again one edge later, to show that it has fallen.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;

   localparam int unsigned CORE_AW = 4;
   localparam int unsigned DW      = 32;

   typedef enum logic [2:0] {
      RI_CMD   = 3'd0,
      RI_SCNT  = 3'd1,
      RI_SADR  = 3'd2,
      RI_SDESC = 3'd3,
      RI_WCNT  = 3'd4,
      RI_WADR  = 3'd5,
      RI_STAT  = 3'd6,
      RI_WDESC = 3'd7
   } reg_idx_e;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_FLUSH = 2'd1,
      OP_ABORT = 2'd2,
      OP_START = 2'd3
   } chan_op_e;

   localparam int unsigned CB_DIR     = 7;
   localparam int unsigned CB_IE_DONE = 6;
   localparam int unsigned CB_IE_CORE = 5;

   localparam int unsigned SB_ERR  = 1;
   localparam int unsigned SB_ABT  = 2;
   localparam int unsigned SB_DONE = 3;
   localparam int unsigned SB_CORE = 4;
   localparam int unsigned STAT_W  = 6;

   localparam int unsigned CTL_W1C = 24;

   localparam logic [DW-1:0] WADR_RST  = 32'hFFFF_FFFF;
   localparam logic [DW-1:0] WDESC_RST = 32'hFFFF_FFFD;

endpackage

// File: rtl/scsi_dma_lane.sv
module scsi_dma_lane
   import scsi_dma_pkg::*;
(
   input  logic [1:0]    off,
   input  logic [1:0]    size,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] cur,
   output logic [DW-1:0] merged,
   output logic [DW-1:0] rdata
);
   logic [4:0]    shamt;
   logic [DW-1:0] szmask;
   logic [DW-1:0] lane_mask;

   always_comb begin
      shamt = {off, 3'b000};
      case (size)
         2'd0:    szmask = 32'h0000_00FF;
         2'd1:    szmask = 32'h0000_FFFF;
         default: szmask = 32'hFFFF_FFFF;
      endcase
      lane_mask = szmask << shamt;
      merged    = (((wdata & szmask) << shamt) & lane_mask) | (cur & ~lane_mask);
      rdata     = (cur >> shamt) & szmask;
   end
endmodule

// File: rtl/scsi_dma_xfer.sv
module scsi_dma_xfer
   import scsi_dma_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             ready,
   input  logic             dir,
   input  logic             cmd_dir,
   input  logic [LEN_W-1:0] req_len,
   input  logic [DW-1:0]    wcnt,
   output logic             accept,
   output logic [LEN_W-1:0] glen,
   output logic [DW-1:0]    remaining
);
   logic [DW-1:0]    req_ext;
   logic [LEN_W-1:0] clamp;

   always_comb begin
      accept    = valid && ready && (dir == cmd_dir);
      req_ext   = DW'(req_len);
      clamp     = (wcnt < req_ext) ? wcnt[LEN_W-1:0] : req_len;
      glen      = accept ? clamp : '0;
      remaining = wcnt - DW'(glen);
   end

   // R5: a direction mismatch never yields a grant
   assert_reject_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && (dir != cmd_dir)) |-> (glen == '0));

   // R4: a grant never exceeds the count left
   assert_grant_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (DW'(glen) <= wcnt));
endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
   import scsi_dma_pkg::*;
#(
   parameter int unsigned IO_AW        = 8,
   parameter int unsigned LEN_W        = 16,
   parameter bit          STRICT_READY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IO_AW-1:0]   io_addr,
   input  logic [1:0]         io_size,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [DW-1:0]      io_wdata,
   output logic [DW-1:0]      io_rdata,
   output logic [CORE_AW-1:0] core_addr,
   output logic               core_wr,
   output logic               core_rd,
   output logic [DW-1:0]      core_wdata,
   input  logic [DW-1:0]      core_rdata,
   input  logic               core_irq,
   input  logic               core_cmd_done,
   output logic               chan_en,
   output logic               abort_req,
   input  logic               xfer_valid,
   input  logic               xfer_dir,
   input  logic [LEN_W-1:0]   xfer_len,
   output logic               xfer_ready,
   output logic [LEN_W-1:0]   xfer_grant,
   output logic [DW-1:0]      xfer_addr,
   output logic               irq
);
   localparam logic [IO_AW-1:0] DMA_LO = IO_AW'(8'h40);
   localparam logic [IO_AW-1:0] DMA_HI = IO_AW'(8'h60);
   localparam logic [IO_AW-3:0] CTL_WI = (IO_AW-2)'(8'h70 >> 2);

   generate
      if (IO_AW < 7) begin : g_bad_aw
         $error("IO_AW must cover the 0x70 control word");
      end
      if (LEN_W < 1 || LEN_W > DW) begin : g_bad_len
         $error("LEN_W must lie between 1 and the data width");
      end
   endgenerate

   logic [7:0]        cmd_q;
   logic [DW-1:0]     scnt_q, sadr_q, sdesc_q;
   logic [DW-1:0]     wcnt_q, wadr_q, wdesc_q;
   logic [STAT_W-1:0] stat_q;
   logic [DW-1:0]     ctl_q;

   logic     in_core, in_dma, in_ctl;
   reg_idx_e idx;
   logic [DW-1:0] cur_word, merged, lane_rdata;

   always_comb begin
      in_core = io_addr < DMA_LO;
      in_dma  = (io_addr >= DMA_LO) && (io_addr < DMA_HI);
      in_ctl  = io_addr[IO_AW-1:2] == CTL_WI;
      idx     = reg_idx_e'(io_addr[4:2]);
      cur_word = '0;
      if (in_core) begin
         cur_word = core_rdata;
      end else if (in_dma) begin
         case (idx)
            RI_CMD:   cur_word = DW'(cmd_q);
            RI_SCNT:  cur_word = scnt_q;
            RI_SADR:  cur_word = sadr_q;
            RI_SDESC: cur_word = sdesc_q;
            RI_WCNT:  cur_word = wcnt_q;
            RI_WADR:  cur_word = wadr_q;
            RI_STAT: begin
               cur_word = DW'(stat_q);
               cur_word[SB_CORE] = stat_q[SB_CORE] | core_irq;
            end
            default:  cur_word = wdesc_q;
         endcase
      end else if (in_ctl) begin
         cur_word = ctl_q;
      end
   end

   scsi_dma_lane u_lane (
      .off    (io_addr[1:0]),
      .size   (io_size),
      .wdata  (io_wdata),
      .cur    (cur_word),
      .merged (merged),
      .rdata  (lane_rdata)
   );

   assign io_rdata   = io_rd ? lane_rdata : '0;
   assign core_addr  = io_addr[5:2];
   assign core_wr    = io_wr && in_core;
   assign core_rd    = io_rd && in_core;
   assign core_wdata = merged;

   logic     dma_wr, cmd_wr, start_hit, stat_rd, stat_wr;
   chan_op_e op;

   always_comb begin
      dma_wr    = io_wr && in_dma;
      cmd_wr    = dma_wr && (idx == RI_CMD);
      op        = chan_op_e'(merged[1:0]);
      start_hit = cmd_wr && (op == OP_START);
      stat_rd   = io_rd && in_dma && (idx == RI_STAT);
      stat_wr   = dma_wr && (idx == RI_STAT);
   end

   generate
      if (STRICT_READY) begin : g_ready_gated
         assign xfer_ready = chan_en;
      end else begin : g_ready_open
         assign xfer_ready = 1'b1;
      end
   endgenerate

   logic             x_accept;
   logic [LEN_W-1:0] x_glen;
   logic [DW-1:0]    x_rem;

   scsi_dma_xfer #(.LEN_W(LEN_W)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (xfer_valid),
      .ready     (xfer_ready),
      .dir       (xfer_dir),
      .cmd_dir   (cmd_q[CB_DIR]),
      .req_len   (xfer_len),
      .wcnt      (wcnt_q),
      .accept    (x_accept),
      .glen      (x_glen),
      .remaining (x_rem)
   );

   assign xfer_grant = x_glen;
   assign xfer_addr  = wadr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         scnt_q    <= '0;
         sadr_q    <= '0;
         sdesc_q   <= '0;
         wcnt_q    <= '0;
         wadr_q    <= WADR_RST;
         wdesc_q   <= WDESC_RST;
         stat_q    <= '0;
         ctl_q     <= '0;
         chan_en   <= 1'b0;
         abort_req <= 1'b0;
      end else begin
         abort_req <= 1'b0;
         if (dma_wr) begin
            case (idx)
               RI_SCNT:  scnt_q  <= merged;
               RI_SADR:  sadr_q  <= merged;
               RI_SDESC: sdesc_q <= merged;
               default:  ;
            endcase
         end
         if (io_wr && in_ctl) ctl_q <= merged;
         if (stat_rd && !ctl_q[CTL_W1C]) begin
            stat_q[SB_ERR]  <= 1'b0;
            stat_q[SB_ABT]  <= 1'b0;
            stat_q[SB_DONE] <= 1'b0;
         end
         if (stat_wr && ctl_q[CTL_W1C]) begin
            if (merged[SB_ERR])  stat_q[SB_ERR]  <= 1'b0;
            if (merged[SB_ABT])  stat_q[SB_ABT]  <= 1'b0;
            if (merged[SB_DONE]) stat_q[SB_DONE] <= 1'b0;
         end
         if (x_accept) begin
            wcnt_q <= x_rem;
            wadr_q <= wadr_q + DW'(x_glen);
            if (x_rem == '0) stat_q[SB_DONE] <= 1'b1;
         end
         if (core_cmd_done) begin
            wcnt_q          <= '0;
            stat_q[SB_DONE] <= 1'b1;
         end
         if (cmd_wr) begin
            cmd_q <= merged[7:0];
            case (op)
               OP_IDLE:  chan_en   <= 1'b0;
               OP_ABORT: abort_req <= 1'b1;
               OP_START: begin
                  wcnt_q  <= scnt_q;
                  wadr_q  <= sadr_q;
                  wdesc_q <= sdesc_q;
                  stat_q  <= '0;
                  chan_en <= 1'b1;
               end
               default:  ;
            endcase
         end
      end
   end

   assign irq = (stat_q[SB_DONE] && cmd_q[CB_IE_DONE]) || (core_irq && cmd_q[CB_IE_CORE]);

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_hit |=> (chan_en && (wcnt_q == $past(scnt_q)) && (wadr_q == $past(sadr_q))));

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (x_accept && !start_hit && !core_cmd_done) |=>
         (wcnt_q == $past(wcnt_q) - DW'($past(xfer_grant))));

   assert_cmd_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (core_cmd_done && !start_hit) |=> (stat_q[SB_DONE] && (wcnt_q == '0)));

   assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ctl_q[CTL_W1C] && !x_accept && !core_cmd_done && !io_wr) |=>
         (stat_q[3:1] == 3'b000));

   assert_abort_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !abort_req);
endmodule

// File: tb/scsi_dma_regs_tb.sv
module scsi_dma_regs_tb;
   localparam int unsigned LEN_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = '0;
   logic [1:0]  io_size = 2'd2;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [31:0] io_wdata = '0, io_rdata;
   logic [3:0]  core_addr;
   logic        core_wr, core_rd;
   logic [31:0] core_wdata;
   logic [31:0] core_rdata = 32'hCAFE_F00D;
   logic        core_irq = 1'b0, core_cmd_done = 1'b0;
   logic        chan_en, abort_req;
   logic        xfer_valid = 1'b0, xfer_dir = 1'b0;
   logic [LEN_W-1:0] xfer_len = '0;
   logic        xfer_ready;
   logic [LEN_W-1:0] xfer_grant;
   logic [31:0] xfer_addr;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   scsi_dma_regs #(.IO_AW(8), .LEN_W(LEN_W), .STRICT_READY(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .io_addr(io_addr), .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .core_addr(core_addr), .core_wr(core_wr), .core_rd(core_rd),
      .core_wdata(core_wdata), .core_rdata(core_rdata),
      .core_irq(core_irq), .core_cmd_done(core_cmd_done),
      .chan_en(chan_en), .abort_req(abort_req),
      .xfer_valid(xfer_valid), .xfer_dir(xfer_dir), .xfer_len(xfer_len),
      .xfer_ready(xfer_ready), .xfer_grant(xfer_grant), .xfer_addr(xfer_addr),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1;
      @(posedge clk); #1;
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
      @(negedge clk);
      io_addr = a; io_size = sz; io_rd = 1'b1;
      #1 d = io_rdata;
      @(posedge clk); #1;
      io_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] exp);
      logic [31:0] v;
      rd(a, sz, v);
      chk(req, v, exp);
   endtask

   task automatic xfer(input logic dir, input logic [LEN_W-1:0] len,
                       output logic [LEN_W-1:0] g, output logic [31:0] ad);
      @(negedge clk);
      xfer_valid = 1'b1; xfer_dir = dir; xfer_len = len;
      #1 g = xfer_grant; ad = xfer_addr;
      @(posedge clk); #1;
      xfer_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [LEN_W-1:0] g;
      logic [31:0] ad;
      int unsigned rem, adr;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 cmd", 8'h40, 2'd2, 32'h0);
      rd_chk("R1 wcnt", 8'h50, 2'd2, 32'h0);
      rd_chk("R1 wadr", 8'h54, 2'd2, 32'hFFFF_FFFF);
      rd_chk("R1 wdesc", 8'h5C, 2'd2, 32'hFFFF_FFFD);
      rd_chk("R1 stat", 8'h58, 2'd2, 32'h0);
      chk("R1 chan_en", {31'b0, chan_en}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 ready", {31'b0, xfer_ready}, 32'h0);

      // R2 START loads working copies
      wr(8'h44, 2'd2, 32'd40);
      wr(8'h48, 2'd2, 32'h2000);
      wr(8'h4C, 2'd2, 32'h3000);
      wr(8'h40, 2'd2, 32'h83);
      chk("R2 chan_en", {31'b0, chan_en}, 32'h1);
      rd_chk("R2 wcnt", 8'h50, 2'd2, 32'd40);
      rd_chk("R2 wadr", 8'h54, 2'd2, 32'h2000);
      rd_chk("R2 wdesc", 8'h5C, 2'd2, 32'h3000);

      // R5 wrong direction
      xfer(1'b0, 16'd5, g, ad);
      chk("R5 grant on mismatch", 32'(g), 32'h0);
      rd_chk("R5 wcnt unchanged", 8'h50, 2'd2, 32'd40);

      // R4 sweep of lengths 0..9, clamp on the last
      rem = 40; adr = 32'h2000;
      for (int l = 0; l < 10; l++) begin
         int unsigned eg;
         eg = (l < rem) ? l : rem;
         xfer(1'b1, LEN_W'(l), g, ad);
         chk("R4 grant", 32'(g), eg);
         chk("R4 addr", ad, adr);
         rem = rem - eg; adr = adr + eg;
      end
      rd_chk("R6 wcnt zero", 8'h50, 2'd2, 32'h0);
      rd_chk("R4 wadr advanced", 8'h54, 2'd2, 32'h2028);
      rd_chk("R6 done set", 8'h58, 2'd2, 32'h08);
      rd_chk("R8 cleared on read", 8'h58, 2'd2, 32'h00);

      // R7 / R12 core interrupt, R3 flush ignored
      core_irq = 1'b1;
      rd_chk("R7 live core bit", 8'h58, 2'd2, 32'h10);
      chk("R12 irq no enable", {31'b0, irq}, 32'h0);
      wr(8'h40, 2'd2, 32'hE1);
      chk("R3 flush keeps chan_en", {31'b0, chan_en}, 32'h1);
      rd_chk("R3 flush keeps wcnt", 8'h50, 2'd2, 32'h0);
      #1 chk("R12 irq core enable", {31'b0, irq}, 32'h1);
      core_irq = 1'b0;
      #1 chk("R12 irq core low", {31'b0, irq}, 32'h0);

      // R9 write-one-to-clear mode, R6 command completion
      wr(8'h70, 2'd2, 32'h0100_0000);
      wr(8'h40, 2'd2, 32'hE3);
      rd_chk("R2 reload", 8'h50, 2'd2, 32'd40);
      @(negedge clk); core_cmd_done = 1'b1;
      @(posedge clk); #1 core_cmd_done = 1'b0;
      rd_chk("R6 completion zeroes count", 8'h50, 2'd2, 32'h0);
      chk("R12 irq on done", {31'b0, irq}, 32'h1);
      rd_chk("R9 read keeps done", 8'h58, 2'd2, 32'h08);
      rd_chk("R9 read keeps done again", 8'h58, 2'd2, 32'h08);
      wr(8'h58, 2'd2, 32'h0);
      rd_chk("R9 zero write keeps", 8'h58, 2'd2, 32'h08);
      wr(8'h58, 2'd2, 32'h08);
      rd_chk("R9 one clears", 8'h58, 2'd2, 32'h00);
      chk("R12 irq after clear", {31'b0, irq}, 32'h0);

      // R10 sub-word merge, R11 extraction
      wr(8'h48, 2'd2, 32'h1122_3344);
      wr(8'h49, 2'd0, 32'hFFFF_FFAA);
      rd_chk("R10 byte merge", 8'h48, 2'd2, 32'h1122_AA44);
      wr(8'h4A, 2'd1, 32'h0000_BEEF);
      rd_chk("R10 half merge", 8'h48, 2'd2, 32'hBEEF_AA44);
      rd_chk("R11 byte read", 8'h4B, 2'd0, 32'hBE);
      rd_chk("R11 half read", 8'h48, 2'd1, 32'hAA44);
      rd_chk("R11 unmapped 0x64", 8'h64, 2'd2, 32'h0);
      rd_chk("R11 unmapped 0x7C", 8'h7C, 2'd2, 32'h0);
      rd_chk("R11 bus control", 8'h70, 2'd2, 32'h0100_0000);

      // R13 core pass-through
      rd_chk("R13 core read", 8'h30, 2'd2, 32'hCAFE_F00D);
      @(negedge clk);
      io_addr = 8'h31; io_size = 2'd0; io_wdata = 32'h77; io_wr = 1'b1;
      #1;
      chk("R13 core_wr", {31'b0, core_wr}, 32'h1);
      chk("R13 core_addr", 32'(core_addr), 32'hC);
      chk("R13 core_wdata", core_wdata, 32'hCAFE_770D);
      @(posedge clk); #1 io_wr = 1'b0;

      // R3 idle and abort, R5 not ready
      wr(8'h40, 2'd2, 32'h80);
      chk("R3 idle halts", {31'b0, chan_en}, 32'h0);
      chk("R5 ready low", {31'b0, xfer_ready}, 32'h0);
      xfer(1'b1, 16'd3, g, ad);
      chk("R5 no grant when idle", 32'(g), 32'h0);
      wr(8'h40, 2'd2, 32'h82);
      chk("R3 abort pulse", {31'b0, abort_req}, 32'h1);
      @(posedge clk); #1;
      chk("R3 abort one cycle", {31'b0, abort_req}, 32'h0);

      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule